// File: doc/BRIEF.md
# Two-Button Dimmer Brightness Controller

This block converts two push inputs (raise and lower) and a slow step-down clock into a lamp brightness. The brightness is given as the conduction angle, in degrees, for a downstream phase-trigger generator, together with a lamp-on flag. Every timing inside the block is counted in pulses of a line-derived `tick` input. Brightness is held internally as a level from 0 (off) to `LVL_MAX` (full). Each level maps to an angle between `MIN_ANG` and `MAX_ANG`.

A press is classified by how long it lasts. A short tap gives a soft ramp. Raising from off goes to a remembered level. Lowering from on goes to off, and the level at that moment is stored. Holding a button moves the brightness continuously, with a slower rate near the bottom of the range. The step-down clock removes one level per falling edge, so `LVL_MAX` edges take the lamp from full to off. A parameter selects the active polarity of the buttons. A second parameter makes every ramp finish in a single step.

Top module: `dimmer_ctrl`

## Requirements
- R1: After reset the angle output is 0 and lamp_on is 0. The remembered level starts at `LVL_MAX`, so the first short raise after reset goes to full brightness.
- R2: Press duration is counted in ticks after a `SYNC_STAGES` synchronizer. A press released with fewer than `SHORT_MIN` ticks has no effect. A press released with more than `SHORT_MAX` ticks but fewer than `LONG_MIN` ticks also has no effect. A release with a count from `SHORT_MIN` to `SHORT_MAX` is a short press. A press still held once its count reaches `LONG_MIN` is a long press until it is released. One press is never both short and long.
- R3: A short raise while the level is 0 ramps the level up to the remembered level, one level every `UP_DIV` ticks. A short raise while the level is nonzero has no effect.
- R4: A short lower while the level is nonzero stores the current level as the remembered level and ramps to 0, one level every `DN_DIV` ticks. A short lower at level 0 has no effect.
- R5: A long raise increases the level while held and stops at `LVL_MAX`. If the level was 0, it first becomes 1 (minimum).
- R6: A long lower decreases the level while held and stops at level 1; it never reaches 0. A long lower at level 0 has no effect.
- R7: During a long press the level moves one step every `SLOW_DIV` ticks while it is below the knee level. From the knee level upward it moves one step every `FAST_DIV` ticks. The knee level is 1 + floor((KNEE_ANG-MIN_ANG)*(LVL_MAX-1)/(MAX_ANG-MIN_ANG)).
- R8: Each synchronized falling edge of doze_in lowers a nonzero level by one. The edge is ignored when the level is 0, when either button is held, and while a ramp is running.
- R9: Angle output is 0 with lamp_on 0 at level 0. At level L≥1 the angle is MIN_ANG + floor(((L-1)*(MAX_ANG-MIN_ANG) + (LVL_MAX-1)/2) / (LVL_MAX-1)), and lamp_on is 1. Both outputs are registered one cycle behind the level.
- R10: While a soft ramp is running, a new press of the opposite button stops the ramp at the current level. That press is then handled from this level.
- R11: With `ACT_LOW`=0 the buttons are active high. With `ACT_LOW`=1 they are active low.
- R12: With `INSTANT`=1, every soft ramp reaches its target on its first step. A long raise jumps to `LVL_MAX` and a long lower jumps to level 1. All other behaviour is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Line-derived timebase pulse, one clock wide |
| up_in | input | 1 | Raise button, raw, polarity set by ACT_LOW |
| dn_in | input | 1 | Lower button, raw, polarity set by ACT_LOW |
| doze_in | input | 1 | Slow step-down clock, acts on falling edges |
| angle | output | AW | Conduction angle in degrees, 0 when off |
| lamp_on | output | 1 | High when the level is nonzero |

## Verification
A wrong level register or a wrong remembered level is visible at the angle output within two clocks of the next step. The bench walks the step-down input through every level from full to off and compares each resulting angle with the mapping. This exposes any off-by-one error in the level or in the angle scaling. Errors in the ramp pacing show up as step spacing that differs from the configured tick counts. The bench measures this spacing exactly in cycles for soft raise, soft lower, and both slopes of a held raise. A faulty press classifier, cancel path or polarity handling leaves the lamp either unchanged or changed after a press. This becomes visible a few cycles after the release.

// File: rtl/dimmer_pkg.sv
package dimmer_pkg;
  typedef enum logic [2:0] {
    MD_IDLE    = 3'd0,
    MD_SOFT_UP = 3'd1,
    MD_SOFT_DN = 3'd2,
    MD_HOLD_UP = 3'd3,
    MD_HOLD_DN = 3'd4
  } ramp_mode_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dimmer_press.sv
module dimmer_press #(
  parameter bit ACT_LOW     = 1'b0,
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_MIN   = 34,
  parameter int SHORT_MAX   = 325,
  parameter int LONG_MIN    = 334
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic btn_raw,
  output logic active,
  output logic start,
  output logic short_evt,
  output logic long_hold
);
  localparam int CW = $clog2(LONG_MIN + 1);
  localparam logic [CW-1:0] C_SMIN = CW'(SHORT_MIN);
  localparam logic [CW-1:0] C_SMAX = CW'(SHORT_MAX);
  localparam logic [CW-1:0] C_LMIN = CW'(LONG_MIN);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          dur_q;
  logic                   now_act;

  assign now_act = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '0;
      dur_q     <= '0;
      active    <= 1'b0;
      start     <= 1'b0;
      short_evt <= 1'b0;
      long_hold <= 1'b0;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], btn_raw ^ ACT_LOW};
      active    <= now_act;
      start     <= now_act & ~active;
      short_evt <= 1'b0;
      if (!now_act) begin
        dur_q <= '0;
        if (active && dur_q >= C_SMIN && dur_q <= C_SMAX)
          short_evt <= 1'b1;
      end else if (tick && dur_q < C_LMIN) begin
        dur_q <= dur_q + 1'b1;
      end
      long_hold <= now_act && (dur_q >= C_LMIN);
    end
  end
endmodule

// File: rtl/dimmer_ramp.sv
module dimmer_ramp
  import dimmer_pkg::*;
#(
  parameter int LVL_MAX  = 83,
  parameter int KNEE_LVL = 16,
  parameter int UP_DIV   = 34,
  parameter int DN_DIV   = 67,
  parameter int SLOW_DIV = 62,
  parameter int FAST_DIV = 40,
  parameter bit INSTANT  = 1'b0,
  parameter int LW       = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start_up,
  input  logic          start_dn,
  input  logic          short_up,
  input  logic          short_dn,
  input  logic          long_up,
  input  logic          long_dn,
  input  logic          any_act,
  input  logic          doze_fall,
  output logic [LW-1:0] lvl
);
  localparam int MAXD = imax(imax(UP_DIV, DN_DIV), imax(SLOW_DIV, FAST_DIV));
  localparam int DW   = $clog2(MAXD + 1);
  localparam logic [LW-1:0] L_MAX  = LW'(LVL_MAX);
  localparam logic [LW-1:0] L_MIN  = LW'(1);
  localparam logic [LW-1:0] L_KNEE = LW'(KNEE_LVL);

  ramp_mode_e    mode;
  logic [LW-1:0] tgt;
  logic [LW-1:0] mem;
  logic [DW-1:0] dcnt;
  int            div_sel;
  logic          step_due;
  logic [LW-1:0] up_next;
  logic [LW-1:0] dn_next;

  always_comb begin
    case (mode)
      MD_SOFT_UP: div_sel = UP_DIV;
      MD_SOFT_DN: div_sel = DN_DIV;
      MD_HOLD_UP,
      MD_HOLD_DN: div_sel = (lvl < L_KNEE) ? SLOW_DIV : FAST_DIV;
      default:    div_sel = 1;
    endcase
  end

  assign step_due = tick && ((int'(dcnt) + 1) >= div_sel);
  assign up_next  = INSTANT ? tgt : lvl + 1'b1;
  assign dn_next  = INSTANT ? tgt : lvl - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MD_IDLE;
      lvl  <= '0;
      tgt  <= '0;
      mem  <= L_MAX;
      dcnt <= '0;
    end else if (long_up) begin
      if (mode != MD_HOLD_UP) begin
        mode <= MD_HOLD_UP;
        dcnt <= '0;
        if (lvl == '0) lvl <= L_MIN;
      end else if (step_due) begin
        dcnt <= '0;
        if (lvl < L_MAX) lvl <= INSTANT ? L_MAX : lvl + 1'b1;
      end else if (tick) begin
        dcnt <= dcnt + 1'b1;
      end
    end else if (long_dn && lvl != '0) begin
      if (mode != MD_HOLD_DN) begin
        mode <= MD_HOLD_DN;
        dcnt <= '0;
      end else if (step_due) begin
        dcnt <= '0;
        if (lvl > L_MIN) lvl <= INSTANT ? L_MIN : lvl - 1'b1;
      end else if (tick) begin
        dcnt <= dcnt + 1'b1;
      end
    end else if (short_up && lvl == '0) begin
      mode <= MD_SOFT_UP;
      tgt  <= mem;
      dcnt <= '0;
    end else if (short_dn && lvl != '0 && mode != MD_SOFT_DN) begin
      mem  <= lvl;
      mode <= MD_SOFT_DN;
      tgt  <= '0;
      dcnt <= '0;
    end else if ((start_up && mode == MD_SOFT_DN) ||
                 (start_dn && mode == MD_SOFT_UP)) begin
      mode <= MD_IDLE;
      dcnt <= '0;
    end else if (doze_fall && !any_act && mode == MD_IDLE && lvl != '0) begin
      lvl <= lvl - 1'b1;
    end else begin
      case (mode)
        MD_SOFT_UP: begin
          if (lvl >= tgt) begin
            mode <= MD_IDLE;
          end else if (step_due) begin
            dcnt <= '0;
            lvl  <= up_next;
            if (up_next == tgt) mode <= MD_IDLE;
          end else if (tick) begin
            dcnt <= dcnt + 1'b1;
          end
        end
        MD_SOFT_DN: begin
          if (lvl == '0) begin
            mode <= MD_IDLE;
          end else if (step_due) begin
            dcnt <= '0;
            lvl  <= dn_next;
            if (dn_next == '0) mode <= MD_IDLE;
          end else if (tick) begin
            dcnt <= dcnt + 1'b1;
          end
        end
        MD_HOLD_UP, MD_HOLD_DN: begin
          mode <= MD_IDLE;
          dcnt <= '0;
        end
        default: dcnt <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dimmer_angle.sv
module dimmer_angle #(
  parameter int LVL_MAX = 83,
  parameter int MIN_ANG = 41,
  parameter int MAX_ANG = 159,
  parameter int LW      = 7,
  parameter int AW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] lvl,
  output logic [AW-1:0] angle,
  output logic          lamp_on
);
  localparam int SPAN = MAX_ANG - MIN_ANG;
  localparam int DEN  = LVL_MAX - 1;
  localparam int HALF = DEN / 2;

  int            scaled;
  logic [AW-1:0] ang_next;

  always_comb begin
    scaled   = (int'(lvl) - 1) * SPAN + HALF;
    ang_next = (lvl == '0) ? '0 : AW'(MIN_ANG + scaled / DEN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      angle   <= '0;
      lamp_on <= 1'b0;
    end else begin
      angle   <= ang_next;
      lamp_on <= (lvl != '0);
    end
  end
endmodule

// File: rtl/dimmer_ctrl.sv
module dimmer_ctrl #(
  parameter bit ACT_LOW     = 1'b0,
  parameter bit INSTANT     = 1'b0,
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_MIN   = 34,
  parameter int SHORT_MAX   = 325,
  parameter int LONG_MIN    = 334,
  parameter int LVL_MAX     = 83,
  parameter int MIN_ANG     = 41,
  parameter int MAX_ANG     = 159,
  parameter int KNEE_ANG    = 64,
  parameter int UP_DIV      = 34,
  parameter int DN_DIV      = 67,
  parameter int SLOW_DIV    = 62,
  parameter int FAST_DIV    = 40,
  parameter int AW          = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          up_in,
  input  logic          dn_in,
  input  logic          doze_in,
  output logic [AW-1:0] angle,
  output logic          lamp_on
);
  localparam int LW       = $clog2(LVL_MAX + 1);
  localparam int KNEE_LVL = 1 + ((KNEE_ANG - MIN_ANG) * (LVL_MAX - 1)) / (MAX_ANG - MIN_ANG);

  logic [1:0]             btn_raw;
  logic [1:0]             ev_act;
  logic [1:0]             ev_start;
  logic [1:0]             ev_short;
  logic [1:0]             ev_long;
  logic [SYNC_STAGES-1:0] dz_sync;
  logic                   dz_last;
  logic                   dz_fall;
  logic [LW-1:0]          lvl;

  assign btn_raw = {dn_in, up_in};

  for (genvar i = 0; i < 2; i++) begin : g_btn
    dimmer_press #(
      .ACT_LOW    (ACT_LOW),
      .SYNC_STAGES(SYNC_STAGES),
      .SHORT_MIN  (SHORT_MIN),
      .SHORT_MAX  (SHORT_MAX),
      .LONG_MIN   (LONG_MIN)
    ) u_press (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .btn_raw  (btn_raw[i]),
      .active   (ev_act[i]),
      .start    (ev_start[i]),
      .short_evt(ev_short[i]),
      .long_hold(ev_long[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dz_sync <= '0;
      dz_last <= 1'b0;
    end else begin
      dz_sync <= {dz_sync[SYNC_STAGES-2:0], doze_in};
      dz_last <= dz_sync[SYNC_STAGES-1];
    end
  end
  assign dz_fall = dz_last & ~dz_sync[SYNC_STAGES-1];

  dimmer_ramp #(
    .LVL_MAX (LVL_MAX),
    .KNEE_LVL(KNEE_LVL),
    .UP_DIV  (UP_DIV),
    .DN_DIV  (DN_DIV),
    .SLOW_DIV(SLOW_DIV),
    .FAST_DIV(FAST_DIV),
    .INSTANT (INSTANT),
    .LW      (LW)
  ) u_ramp (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .start_up (ev_start[0]),
    .start_dn (ev_start[1]),
    .short_up (ev_short[0]),
    .short_dn (ev_short[1]),
    .long_up  (ev_long[0]),
    .long_dn  (ev_long[1]),
    .any_act  (|ev_act),
    .doze_fall(dz_fall),
    .lvl      (lvl)
  );

  dimmer_angle #(
    .LVL_MAX(LVL_MAX),
    .MIN_ANG(MIN_ANG),
    .MAX_ANG(MAX_ANG),
    .LW     (LW),
    .AW     (AW)
  ) u_angle (
    .clk    (clk),
    .rst    (rst),
    .lvl    (lvl),
    .angle  (angle),
    .lamp_on(lamp_on)
  );
endmodule

// File: rtl/dimmer_ctrl_chk.sv
module dimmer_ctrl_chk #(
  parameter int LVL_MAX = 83,
  parameter int MIN_ANG = 41,
  parameter int MAX_ANG = 159,
  parameter bit INSTANT = 1'b0,
  parameter int LW      = 7,
  parameter int AW      = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] angle,
  input logic          lamp_on,
  input logic [LW-1:0] lvl,
  input logic [1:0]    ev_short,
  input logic [1:0]    ev_long
);
  // R9
  angle_range_chk: assert property (@(posedge clk) disable iff (rst)
    lamp_on |-> (angle >= AW'(MIN_ANG) && angle <= AW'(MAX_ANG)));

  // R9
  angle_off_chk: assert property (@(posedge clk) disable iff (rst)
    !lamp_on |-> (angle == '0));

  // R9
  lamp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lamp_on == ($past(lvl) != '0)));

  // R5
  lvl_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    lvl <= LW'(LVL_MAX));

  // R6
  hold_dn_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_long[1] && !ev_long[0] && lvl != '0) |=> (lvl != '0));

  // R2
  short_long_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_short & ev_long) == 2'b00);

  if (INSTANT == 1'b0) begin : g_step
    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
      (lvl == $past(lvl)) || (lvl == $past(lvl) + 1'b1) || (lvl + 1'b1 == $past(lvl)));
  end
endmodule

bind dimmer_ctrl dimmer_ctrl_chk #(
  .LVL_MAX(LVL_MAX),
  .MIN_ANG(MIN_ANG),
  .MAX_ANG(MAX_ANG),
  .INSTANT(INSTANT),
  .LW     (LW),
  .AW     (AW)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .angle   (angle),
  .lamp_on (lamp_on),
  .lvl     (lvl),
  .ev_short(ev_short),
  .ev_long (ev_long)
);

// File: tb/dimmer_ctrl_tb.sv
module dimmer_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_CYC   = 2;
  localparam int SMIN = 4, SMAX = 20, LMIN = 24;
  localparam int LMAX = 83, AMIN = 41, AMAX = 159, KANG = 64;
  localparam int UPD = 2, DND = 4, SLD = 3, FSD = 1;
  localparam int KLVL = 1 + ((KANG - AMIN) * (LMAX - 1)) / (AMAX - AMIN);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       up = 1'b0, dn = 1'b0, doze = 1'b0;
  logic [7:0] ang1, ang2;
  logic       on1, on2;
  int         cyc = 0;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tick <= ~tick;

  dimmer_ctrl #(
    .ACT_LOW(1'b0), .INSTANT(1'b0), .SYNC_STAGES(2),
    .SHORT_MIN(SMIN), .SHORT_MAX(SMAX), .LONG_MIN(LMIN),
    .LVL_MAX(LMAX), .MIN_ANG(AMIN), .MAX_ANG(AMAX), .KNEE_ANG(KANG),
    .UP_DIV(UPD), .DN_DIV(DND), .SLOW_DIV(SLD), .FAST_DIV(FSD), .AW(8)
  ) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .up_in(up), .dn_in(dn),
    .doze_in(doze), .angle(ang1), .lamp_on(on1)
  );

  dimmer_ctrl #(
    .ACT_LOW(1'b1), .INSTANT(1'b1), .SYNC_STAGES(2),
    .SHORT_MIN(SMIN), .SHORT_MAX(SMAX), .LONG_MIN(LMIN),
    .LVL_MAX(LMAX), .MIN_ANG(AMIN), .MAX_ANG(AMAX), .KNEE_ANG(KANG),
    .UP_DIV(UPD), .DN_DIV(DND), .SLOW_DIV(SLD), .FAST_DIV(FSD), .AW(8)
  ) u_dut2 (
    .clk(clk), .rst(rst), .tick(tick), .up_in(~up), .dn_in(~dn),
    .doze_in(doze), .angle(ang2), .lamp_on(on2)
  );

  function automatic int exp_ang(input int l);
    if (l == 0) return 0;
    return AMIN + ((l - 1) * (AMAX - AMIN) + (LMAX - 1) / 2) / (LMAX - 1);
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wait_ang(input string req, input int target, input int lim, output int at);
    at = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (int'(ang1) == target) begin
        at = cyc;
        break;
      end
    end
    if (at < 0) chk(req, int'(ang1), target);
  endtask

  task automatic press_up(input int ticks);
    @(negedge clk); up = 1'b1;
    repeat (ticks * TICK_CYC) @(negedge clk);
    up = 1'b0;
  endtask

  task automatic press_dn(input int ticks);
    @(negedge clk); dn = 1'b1;
    repeat (ticks * TICK_CYC) @(negedge clk);
    dn = 1'b0;
  endtask

  task automatic doze_pulse();
    @(negedge clk); doze = 1'b1;
    repeat (4) @(negedge clk);
    doze = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c1, c2, c3, c4;
    int v1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 angle after reset", int'(ang1), 0);
    chk("R1 lamp after reset", int'(on1), 0);
    chk("R1 angle after reset, second instance", int'(ang2), 0);

    // R4 short lower while off: no effect
    press_dn(10); repeat (40) @(negedge clk);
    chk("R4 short lower when off", int'(ang1), 0);
    // R6 long lower while off: no effect
    press_dn(40); repeat (20) @(negedge clk);
    chk("R6 long lower when off", int'(ang1), 0);
    chk("R6 long lower when off, second instance", int'(ang2), 0);
    // R8 doze while off: no effect
    repeat (3) doze_pulse();
    chk("R8 doze when off", int'(on1), 0);
    // R2 too short, and between windows
    press_up(2); repeat (40) @(negedge clk);
    chk("R2 press below short window ignored", int'(ang1), 0);
    press_up(22); repeat (40) @(negedge clk);
    chk("R2 press between windows ignored", int'(ang1), 0);

    // R3 / R1 short raise from off goes to full (default memory)
    press_up(10);
    wait_ang("R3 soft raise reaches min", exp_ang(1), 200, c1);
    // R12 / R11 instant instance with active-low buttons jumps at the same step
    chk("R12 instant raise at first step", int'(ang2), AMAX);
    wait_ang("R1 soft raise to default memory", AMAX, 1000, c2);
    chk("R3 soft raise spacing", c2 - c1, (LMAX - 1) * UPD * TICK_CYC);
    press_up(10); repeat (40) @(negedge clk);
    chk("R3 short raise while on ignored", int'(ang1), AMAX);
    chk("R11 active-low instance unchanged", int'(ang2), AMAX);

    // R8 / R9 doze sweep over every level, full to off
    for (int k = 1; k <= LMAX; k++) begin
      doze_pulse();
      chk("R9 doze step angle", int'(ang1), exp_ang(LMAX - k));
      chk("R8 doze step angle, second instance", int'(ang2), exp_ang(LMAX - k));
    end
    chk("R8 lamp off after full doze count", int'(on1), 0);

    // R5 / R7 long raise from off
    @(negedge clk); up = 1'b1;
    wait_ang("R5 long raise starts at min", exp_ang(1), 200, c1);
    wait_ang("R7 slow slope start", exp_ang(2), 200, c1);
    wait_ang("R7 knee reached", exp_ang(KLVL), 500, c2);
    chk("R7 slow slope spacing", c2 - c1, (KLVL - 2) * SLD * TICK_CYC);
    wait_ang("R7 fast slope", exp_ang(KLVL + 14), 500, c3);
    chk("R7 fast slope spacing", c3 - c2, 14 * FSD * TICK_CYC);
    wait_ang("R5 long raise to max", AMAX, 1000, c4);
    repeat (40) @(negedge clk);
    chk("R5 long raise stops at max", int'(ang1), AMAX);
    chk("R12 instant long raise", int'(ang2), AMAX);
    up = 1'b0; repeat (10) @(negedge clk);

    // R6 long lower stops at min
    @(negedge clk); dn = 1'b1;
    wait_ang("R6 long lower to min", AMIN, 2000, c1);
    repeat (60) @(negedge clk);
    chk("R6 long lower holds at min", int'(ang1), AMIN);
    chk("R6 lamp stays on at min", int'(on1), 1);
    chk("R12 instant long lower", int'(ang2), AMIN);
    dn = 1'b0; repeat (10) @(negedge clk);

    // R4 / R3 memory of a mid level
    @(negedge clk); up = 1'b1;
    wait_ang("R5 long raise again", AMAX, 2000, c1);
    up = 1'b0; repeat (10) @(negedge clk);
    repeat (33) doze_pulse();
    chk("R8 doze to level 50", int'(ang1), exp_ang(50));
    press_dn(10);
    wait_ang("R4 soft lower begins", exp_ang(49), 200, c1);
    wait_ang("R4 soft lower to off", 0, 2000, c2);
    chk("R4 soft lower spacing", c2 - c1, 49 * DND * TICK_CYC);
    chk("R4 lamp off after soft lower", int'(on1), 0);
    chk("R12 instant soft lower", int'(ang2), 0);
    press_up(10);
    wait_ang("R3 raise to stored level", exp_ang(50), 1000, c1);
    repeat (30) @(negedge clk);
    chk("R3 stops at stored level", int'(ang1), exp_ang(50));
    chk("R12 instant raise to stored level", int'(ang2), exp_ang(50));

    // R10 cancel soft lower by a raise press; R8 doze ignored while held
    press_dn(10);
    wait_ang("R10 soft lower running", exp_ang(40), 500, c1);
    @(negedge clk); up = 1'b1;
    repeat (8) @(negedge clk);
    v1 = int'(ang1);
    chk("R10 frozen level within range", int'(v1 <= exp_ang(40) && v1 >= exp_ang(38)), 1);
    doze_pulse();
    repeat (6) @(negedge clk);
    chk("R10 ramp stopped by opposite press", int'(ang1), v1);
    chk("R8 doze ignored while button held", int'(ang1), v1);
    up = 1'b0;
    repeat (30) @(negedge clk);
    chk("R3 short raise after cancel has no effect", int'(ang1), v1);
    chk("R10 lamp still on", int'(on1), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule